// File: doc/BRIEF.md
# Color Lookup Table Loader

This block holds a 256-entry color lookup table. Each entry has a red, a green and a blue component, 8 bits each. Software fills the table through a write-only window of four 32-bit registers. A write to the index register selects an entry. Three writes to the data register then supply red, green and blue for that entry, in that order. After the blue write the index moves to the next entry, so a whole table can be loaded as one long stream of data writes after a single index write.

Each color value, and the index, is taken from the most significant byte of the 32-bit write word. A write to the index register at any point restarts the color sequence at red. A separate lookup port serves the pixel path. It returns the three components of any entry, selected by an 8-bit pixel value, and bus traffic does not disturb it. A parameter makes that port either combinational or registered with one cycle of latency.

Top module: `clut_loader`

## Requirements
- R1: After reset every entry reads as black (all components 0), except entry 255, which reads as white (all components 255). The index is 0 and the next data write goes to red.
- R2: An accepted write at byte offset 0 loads the index from write data bits 31:24 and makes the next data write go to red, even if a color sequence is half done.
- R3: Accepted writes at byte offset 4 store write data bits 31:24 into the red, then green, then blue component of the entry the index selects. The other components of that entry keep their values.
- R4: After the blue write the index increases by one, wrapping from 255 to 0, and the next data write goes to red.
- R5: Every bus read returns 0 on bus_rdata, and a read has no effect on the table, the index or the sequence.
- R6: A write is accepted only when all four byte enables are 1 (4'b1111) and the offset is 0 or 4. Writes to offsets 8 or 12, writes to offsets that are not word aligned, and partial writes change nothing.
- R7: A component written on a clock edge appears on the lookup outputs for that entry in the next cycle when LOOKUP_LAT is 0. When LOOKUP_LAT is 1 it appears one cycle later, and every lookup then returns the entry selected in the previous cycle.
- R8: The lookup outputs for a fixed lookup index do not change while the bus reads, makes ignored writes, or writes other entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset within the register window |
| bus_be | input | 4 | Byte enables; only 4'b1111 is accepted |
| bus_wdata | input | 32 | Write data; bits 31:24 carry the index or color value |
| bus_rdata | output | 32 | Read data, always 0 |
| lut_idx | input | 8 | Entry selected by the pixel path |
| lut_red | output | 8 | Red component of the selected entry |
| lut_green | output | 8 | Green component of the selected entry |
| lut_blue | output | 8 | Blue component of the selected entry |

## Verification
The bench builds two copies of the block side by side on the same bus and lookup index, both with the default 32-bit bus and 256 entries. One copy uses LOOKUP_LAT 0 and the other LOOKUP_LAT 1, so both generate variants of the lookup port face the same write stream, and the registered copy's extra cycle of delay is checked against the combinational one. With 256 entries, a random stream of index and data writes reaches the 255-to-0 wrap of the index. A sweep of all entries then compares both copies against a model.

// File: rtl/clut_pkg.sv
package clut_pkg;

   // Which component the next data write fills
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_t;

   localparam int unsigned NUM_CHAN = 3;

endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned IDX_OFF = 0,
   parameter int unsigned COL_OFF = 4
) (
   input  logic                  bus_valid,
   input  logic                  bus_write,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W/8-1:0]   bus_be,
   output logic                  load_idx,
   output logic                  put_col
);
   logic full_wr;

   // Only complete word writes count; anything else is dropped
   always_comb begin
      full_wr  = bus_valid && bus_write && (&bus_be);
      load_idx = full_wr && (bus_addr == ADDR_W'(IDX_OFF));
      put_col  = full_wr && (bus_addr == ADDR_W'(COL_OFF));
   end

endmodule

// File: rtl/clut_sequencer.sv
module clut_sequencer
   import clut_pkg::*;
#(
   parameter int unsigned IDX_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load_idx,
   input  logic                 put_col,
   input  logic [IDX_W-1:0]     new_idx,
   output logic [IDX_W-1:0]     cur_idx,
   output phase_t               cur_phase,
   output logic [NUM_CHAN-1:0]  wr_en
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx   <= '0;
         cur_phase <= PH_RED;
      end else if (load_idx) begin
         cur_idx   <= new_idx;
         cur_phase <= PH_RED;
      end else if (put_col) begin
         unique case (cur_phase)
            PH_RED:  cur_phase <= PH_GRN;
            PH_GRN:  cur_phase <= PH_BLU;
            default: begin
               cur_phase <= PH_RED;
               cur_idx   <= cur_idx + 1'b1;
            end
         endcase
      end
   end

   // One write lane per component
   always_comb begin
      wr_en    = '0;
      wr_en[0] = put_col && (cur_phase == PH_RED);
      wr_en[1] = put_col && (cur_phase == PH_GRN);
      wr_en[2] = put_col && (cur_phase == PH_BLU);
   end

endmodule

// File: rtl/clut_store.sv
module clut_store
   import clut_pkg::*;
#(
   parameter int unsigned ENTRIES    = 256,
   parameter int unsigned CHAN_W     = 8,
   parameter int unsigned LOOKUP_LAT = 0,
   localparam int unsigned IDX_W     = $clog2(ENTRIES),
   localparam int unsigned LANE_W    = NUM_CHAN * CHAN_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CHAN-1:0]  wr_en,
   input  logic [IDX_W-1:0]     wr_addr,
   input  logic [CHAN_W-1:0]    wr_val,
   input  logic [IDX_W-1:0]     rd_idx,
   output logic [LANE_W-1:0]    rd_rgb
);
   logic [LANE_W-1:0] lane;

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      logic [CHAN_W-1:0] mem [ENTRIES];

      // Last entry comes up white, all others black
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
               mem[i] <= (i == ENTRIES - 1) ? '1 : '0;
            end
         end else if (wr_en[c]) begin
            mem[wr_addr] <= wr_val;
         end
      end

      assign lane[c*CHAN_W +: CHAN_W] = mem[rd_idx];
   end

   if (LOOKUP_LAT == 0) begin : g_comb
      assign rd_rgb = lane;
   end else begin : g_reg
      logic [LANE_W-1:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane_q <= '0;
         else        lane_q <= lane;
      end
      assign rd_rgb = lane_q;
   end

endmodule

// File: rtl/clut_loader.sv
module clut_loader
   import clut_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WIN_BYTES  = 16,
   parameter int unsigned ENTRIES    = 256,
   parameter int unsigned CHAN_W     = 8,
   parameter int unsigned LOOKUP_LAT = 0,
   localparam int unsigned ADDR_W    = $clog2(WIN_BYTES),
   localparam int unsigned IDX_W     = $clog2(ENTRIES),
   localparam int unsigned BE_W      = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BE_W-1:0]    bus_be,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [IDX_W-1:0]   lut_idx,
   output logic [CHAN_W-1:0]  lut_red,
   output logic [CHAN_W-1:0]  lut_green,
   output logic [CHAN_W-1:0]  lut_blue
);
   // Elaboration-time parameter checks
   if (ENTRIES != (1 << IDX_W)) begin : g_bad_entries
      $error("ENTRIES must be a power of two");
   end
   if (CHAN_W >= DATA_W || IDX_W >= DATA_W) begin : g_bad_width
      $error("index and color fields must fit in the bus word");
   end
   if (WIN_BYTES < 8 || DATA_W % 8 != 0) begin : g_bad_window
      $error("window must hold two word registers");
   end
   if (LOOKUP_LAT > 1) begin : g_bad_lat
      $error("LOOKUP_LAT must be 0 or 1");
   end

   logic                    load_idx;
   logic                    put_col;
   logic [IDX_W-1:0]        cur_idx;
   phase_t                  cur_phase;
   logic [NUM_CHAN-1:0]     wr_en;
   logic [NUM_CHAN*CHAN_W-1:0] rd_rgb;
   logic                    unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-CHAN_W-1:0];
   assign bus_rdata    = '0;

   clut_bus_decode #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .IDX_OFF (0),
      .COL_OFF (BE_W)
   ) u_decode (
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .load_idx  (load_idx),
      .put_col   (put_col)
   );

   clut_sequencer #(
      .IDX_W (IDX_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_idx  (load_idx),
      .put_col   (put_col),
      .new_idx   (bus_wdata[DATA_W-1 -: IDX_W]),
      .cur_idx   (cur_idx),
      .cur_phase (cur_phase),
      .wr_en     (wr_en)
   );

   clut_store #(
      .ENTRIES    (ENTRIES),
      .CHAN_W     (CHAN_W),
      .LOOKUP_LAT (LOOKUP_LAT)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (cur_idx),
      .wr_val  (bus_wdata[DATA_W-1 -: CHAN_W]),
      .rd_idx  (lut_idx),
      .rd_rgb  (rd_rgb)
   );

   assign lut_red   = rd_rgb[0*CHAN_W +: CHAN_W];
   assign lut_green = rd_rgb[1*CHAN_W +: CHAN_W];
   assign lut_blue  = rd_rgb[2*CHAN_W +: CHAN_W];

endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk
   import clut_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned CHAN_W     = 8,
   parameter int unsigned LOOKUP_LAT = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_valid,
   input logic               bus_write,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W/8-1:0] bus_be,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [IDX_W-1:0]   lut_idx,
   input logic [CHAN_W-1:0]  lut_red,
   input logic [IDX_W-1:0]   cur_idx,
   input phase_t             cur_phase
);
   logic full_wr, idx_wr, col_wr;
   assign full_wr = bus_valid && bus_write && (bus_be == '1);
   assign idx_wr  = full_wr && (bus_addr == ADDR_W'(0));
   assign col_wr  = full_wr && (bus_addr == ADDR_W'(DATA_W/8));

   // R2
   index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> (cur_idx == $past(bus_wdata[DATA_W-1 -: IDX_W])) && (cur_phase == PH_RED));

   // R3
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_wr && cur_phase == PH_RED) |=> (cur_phase == PH_GRN) && $stable(cur_idx));

   // R4
   index_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_wr && cur_phase == PH_BLU) |=>
         (cur_idx == IDX_W'($past(cur_idx) + 1'b1)) && (cur_phase == PH_RED));

   // R6
   no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(idx_wr || col_wr) |=> $stable(cur_idx) && $stable(cur_phase));

   if (LOOKUP_LAT == 0) begin : g_lat0
      // R7
      lookup_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (col_wr && cur_phase == PH_RED) |=>
            (lut_idx != $past(cur_idx)) || (lut_red == $past(bus_wdata[DATA_W-1 -: CHAN_W])));
   end

endmodule

bind clut_loader clut_loader_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .IDX_W      (IDX_W),
   .CHAN_W     (CHAN_W),
   .LOOKUP_LAT (LOOKUP_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .lut_idx   (lut_idx),
   .lut_red   (lut_red),
   .cur_idx   (cur_idx),
   .cur_phase (cur_phase)
);

// File: tb/clut_loader_bench.sv
module clut_loader_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [7:0]  lut_idx = '0;
   logic [31:0] rdata_c, rdata_r;
   logic [7:0]  red_c, grn_c, blu_c, red_r, grn_r, blu_r;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Model state
   logic [7:0] m_r [256];
   logic [7:0] m_g [256];
   logic [7:0] m_b [256];
   logic [7:0] m_idx;
   int         m_ph;

   always #(CLK_PERIOD/2) clk = ~clk;

   clut_loader #(.LOOKUP_LAT(0)) u_clut_loader (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_c),
      .lut_idx(lut_idx), .lut_red(red_c), .lut_green(grn_c), .lut_blue(blu_c));

   clut_loader #(.LOOKUP_LAT(1)) u_clut_loader_reg (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(rdata_r),
      .lut_idx(lut_idx), .lut_red(red_r), .lut_green(grn_r), .lut_blue(blu_r));

   function automatic logic [23:0] expect_rgb(input logic [7:0] i);
      return {m_r[i], m_g[i], m_b[i]};
   endfunction

   function automatic bit accepted(input logic [3:0] a, input logic [3:0] be);
      return (be == 4'hF) && (a == 4'd0 || a == 4'd4);
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 256; i++) begin
         m_r[i] = (i == 255) ? 8'hFF : 8'h00;
         m_g[i] = (i == 255) ? 8'hFF : 8'h00;
         m_b[i] = (i == 255) ? 8'hFF : 8'h00;
      end
      m_idx = 8'd0;
      m_ph  = 0;
   endtask

   task automatic model_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be);
      if (!accepted(a, be)) return;
      if (a == 4'd0) begin
         m_idx = d[31:24];
         m_ph  = 0;
      end else begin
         case (m_ph)
            0: begin m_r[m_idx] = d[31:24]; m_ph = 1; end
            1: begin m_g[m_idx] = d[31:24]; m_ph = 2; end
            default: begin m_b[m_idx] = d[31:24]; m_idx = m_idx + 8'd1; m_ph = 0; end
         endcase
      end
   endtask

   // One bus cycle; reads are checked for zero data while they are driven
   task automatic bus_op(input bit wr, input logic [3:0] a, input logic [31:0] d,
                         input logic [3:0] be);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d; bus_be = be;
      if (!wr) begin
         #1;
         checks++;
         if (rdata_c !== 32'd0 || rdata_r !== 32'd0) begin
            fails++;
            $display("FAIL R5 read data actual %h/%h expected 0", rdata_c, rdata_r);
         end
      end
      @(posedge clk);
      #1;
      if (wr) model_write(a, d, be);
      bus_valid = 1'b0; bus_write = 1'b0;
   endtask

   // Select an entry, let the registered copy catch up, compare both copies
   task automatic check_entry(input logic [7:0] i, input string tag);
      logic [23:0] e;
      @(negedge clk);
      lut_idx = i;
      @(negedge clk);
      e = expect_rgb(i);
      checks++;
      if ({red_c, grn_c, blu_c} !== e || {red_r, grn_r, blu_r} !== e) begin
         fails++;
         $display("FAIL %s entry %0d actual comb %h reg %h expected %h",
                  tag, i, {red_c, grn_c, blu_c}, {red_r, grn_r, blu_r}, e);
      end
   endtask

   task automatic check_hold(input logic [7:0] i, input string tag);
      logic [23:0] e;
      e = expect_rgb(i);
      checks++;
      if ({red_c, grn_c, blu_c} !== e || {red_r, grn_r, blu_r} !== e) begin
         fails++;
         $display("FAIL %s entry %0d actual comb %h reg %h expected %h",
                  tag, i, {red_c, grn_c, blu_c}, {red_r, grn_r, blu_r}, e);
      end
   endtask

   task automatic put(input logic [7:0] v);
      bus_op(1'b1, 4'd4, {v, 24'h5A5A5A}, 4'hF);
   endtask

   task automatic set_index(input logic [7:0] v);
      bus_op(1'b1, 4'd0, {v, 24'hA5A5A5}, 4'hF);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [23:0] e;
      void'($urandom(32'd4177));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents
      check_entry(8'd0,   "R1");
      check_entry(8'd128, "R1");
      check_entry(8'd255, "R1");

      // R1 index 0 and red phase after reset; R3 component order
      put(8'h11);
      check_entry(8'd0, "R1");
      put(8'h22);
      put(8'h33);
      check_entry(8'd0, "R3");
      // R4 index advanced to 1
      put(8'h44);
      check_entry(8'd1, "R4");

      // R2 index write mid-sequence restarts at red
      set_index(8'd20);
      put(8'h01);
      put(8'h02);
      set_index(8'd30);
      put(8'h07);
      check_entry(8'd20, "R2");
      check_entry(8'd30, "R2");

      // R4 wrap from 255 to 0
      set_index(8'd255);
      put(8'h10); put(8'h20); put(8'h30);
      put(8'h99);
      check_entry(8'd255, "R4");
      check_entry(8'd0,   "R4");

      // R6 ignored offsets, misaligned and partial writes; R5 reads
      set_index(8'd40);
      bus_op(1'b1, 4'd8,  32'hEE000000, 4'hF);
      bus_op(1'b1, 4'd12, 32'hEE000000, 4'hF);
      bus_op(1'b1, 4'd5,  32'hEE000000, 4'hF);
      bus_op(1'b1, 4'd4,  32'hEE000000, 4'h7);
      bus_op(1'b1, 4'd0,  32'h77000000, 4'hE);
      bus_op(1'b0, 4'd4,  32'hEE000000, 4'hF);
      bus_op(1'b0, 4'd0,  32'h77000000, 4'hF);
      check_entry(8'd40,  "R6");
      put(8'h6B);
      check_entry(8'd40,  "R6");
      check_entry(8'd119, "R6");

      // R7 lookup of an entry right after its write
      set_index(8'd50);
      @(negedge clk);
      lut_idx = 8'd50;
      put(8'hC3);
      @(negedge clk);
      checks++;
      if (red_c !== 8'hC3) begin
         fails++;
         $display("FAIL R7 comb red actual %h expected c3", red_c);
      end
      checks++;
      if (red_r !== 8'h00) begin
         fails++;
         $display("FAIL R7 reg red one cycle late actual %h expected 00", red_r);
      end
      @(negedge clk);
      checks++;
      if (red_r !== 8'hC3) begin
         fails++;
         $display("FAIL R7 reg red actual %h expected c3", red_r);
      end

      // R8 lookup held while the bus works elsewhere
      @(negedge clk);
      lut_idx = 8'd30;
      @(negedge clk);
      set_index(8'd60);
      check_hold(8'd30, "R8");
      put(8'h81); check_hold(8'd30, "R8");
      bus_op(1'b0, 4'd4, 32'd0, 4'hF); check_hold(8'd30, "R8");
      bus_op(1'b1, 4'd8, 32'hFF000000, 4'hF); check_hold(8'd30, "R8");
      put(8'h82); put(8'h83); check_hold(8'd30, "R8");

      // Random stream over all offsets and byte enables
      for (int n = 0; n < 1500; n++) begin
         int k;
         k = $urandom % 10;
         case (k)
            0: set_index(8'($urandom));
            1, 2, 3, 4, 5: put(8'($urandom));
            6: bus_op(1'b0, 4'($urandom), $urandom, 4'hF);
            7: bus_op(1'b1, 4'd8 + 4'(4 * ($urandom % 2)), $urandom, 4'hF);
            8: bus_op(1'b1, 4'd4 * 4'($urandom % 2), $urandom, 4'($urandom % 15));
            default: bus_op(1'b1, 4'($urandom), $urandom, 4'($urandom));
         endcase
      end

      // Sweep of the whole table: R3 R4 R6 after random traffic
      for (int i = 0; i < 256; i++) begin
         check_entry(8'(i), "R3");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule